// File: doc/BRIEF.md
# Configuration Space Access Sequencer

This block sits between a host that issues configuration reads and writes of one, two or four bytes and a downstream configuration port that only runs aligned 32-bit cycles through an address/data register pair. For each accepted host request the sequencer first loads the port's address register with a formed configuration address word. It then reads or writes the port's data register. It extracts or merges byte and halfword values using a big-endian lane mapping.

Requests that name a bus or device/function beyond the supported range are answered at once with a not-found status and cause no port cycle. Byte and halfword writes become a full-word read, a merge and a full-word write, all inside one host operation. A data read that the port reports as timed out is treated as an all-ones word.

Top module: `cfg_access_seq`

## Requirements
- R1: The address word written to the port is bus<<16 | devfn<<8 | (offset & 0xFC), with bit 0 set to 1 exactly when the bus number is nonzero (Type 1) and 0 for bus zero (Type 0).
- R2: Every accepted, in-range operation starts with one write to port address CSR_BASE+0x500. All of its data cycles then go to CSR_BASE+0x504.
- R3: A request with bus > 7 or devfn > 127 makes no port cycle and responds with not-found (rsp_notfound=1). A rejected read returns zero-extended all ones of the requested width (0xFF, 0xFFFF, 0xFFFFFFFF). A rejected write changes nothing.
- R4: A byte read (size code 0) returns, zero-extended, byte lane (offset[1:0] XOR 3) of the fetched word, where lane 0 is bits 7:0.
- R5: A halfword read (size code 1) selects halfword bit 1 of (offset XOR 2), where halfword 0 is bits 15:0 and halfword 1 is bits 31:16, and returns it zero-extended.
- R6: A word read (size code 2 or 3) returns the fetched 32-bit word unchanged.
- R7: A byte or halfword write performs one data read and then one data write of the fetched word, with only the selected lane(s) replaced by the low bits of the write data. All other bytes are preserved.
- R8: A word write performs exactly one data write of the full write data and no data read.
- R9: A data read completed with the timeout flag yields the word 0xFFFFFFFF. Reads then return all ones at their width, and a sub-word write merges into an all-ones word.
- R10: At most one port cycle is outstanding. prt_req is a one-cycle pulse and is not raised again before prt_done. req_ready is low from acceptance until the response.
- R11: Each accepted request produces exactly one single-cycle rsp_valid. rsp_notfound=0 for in-range requests and rsp_rdata=0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device/function number |
| req_offset | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data, zero-extended |
| rsp_notfound | output | 1 | 1 = request rejected as out of range |
| prt_req | output | 1 | Port cycle strobe |
| prt_we | output | 1 | Port cycle is a write |
| prt_addr | output | 16 | Port register address |
| prt_wdata | output | 32 | Port write data |
| prt_done | input | 1 | Port cycle complete |
| prt_rdata | input | 32 | Port read data, valid with prt_done |
| prt_timeout | input | 1 | Port cycle timed out, valid with prt_done |

## Verification
A corrupted latched request shows at the port as a wrong address word or at the response as data from the wrong lane. It is visible on the first port cycle or on the response, within a few cycles of acceptance. A stuck or skipped sequencer state shows as a missing or extra data read or write, which the port model counts per operation. It can also leave the response missing, which the bench's wait-loop guard catches. A faulty merge leaves neighbouring bytes altered, and the full-word read-back right after each write exposes it.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD2 = 2'd3} acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_AWR, ST_AWAIT, ST_DRD, ST_RWAIT, ST_DWR, ST_WWAIT, ST_RESP
  } seq_state_e;

  // big-endian lane mapping: byte lane index inside the 32-bit word
  function automatic logic [1:0] byte_lane(input logic [1:0] ofs);
    return ofs ^ 2'b11;
  endfunction

  // halfword select: 1 means bits 31:16
  function automatic logic half_sel(input logic [1:0] ofs);
    logic [1:0] t;
    t = ofs ^ 2'b10;
    return t[1];
  endfunction

  function automatic logic [WORD_W-1:0] size_ones(input acc_size_e sz);
    case (sz)
      SZ_BYTE: return WORD_W'(8'hFF);
      SZ_HALF: return WORD_W'(16'hFFFF);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/cfg_addr_form.sv
module cfg_addr_form #(
  parameter int BUS_W     = 8,
  parameter int DEVFN_W   = 8,
  parameter int OFS_W     = 8,
  parameter int MAX_BUS   = 7,
  parameter int MAX_DEVFN = 127
) (
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [OFS_W-3:0]   ofs_hi,
  output logic               out_of_range,
  output logic [31:0]        addr_word
);
  localparam logic [BUS_W-1:0]   BUS_LIM   = BUS_W'(MAX_BUS);
  localparam logic [DEVFN_W-1:0] DEVFN_LIM = DEVFN_W'(MAX_DEVFN);

  always_comb begin
    out_of_range = (bus > BUS_LIM) || (devfn > DEVFN_LIM);
    addr_word = '0;
    addr_word[16 +: BUS_W]   = bus;
    addr_word[8 +: DEVFN_W]  = devfn;
    addr_word[OFS_W-1:2]     = ofs_hi;
    addr_word[0]             = |bus;   // Type 1 for any bus beyond the primary
  end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
  import cfg_seq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  acc_size_e         size,
  input  logic [1:0]        ofs,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_val,
  output logic [WORD_W-1:0] merged
);
  always_comb begin
    case (size)
      SZ_BYTE: rd_val = WORD_W'(word[8*byte_lane(ofs) +: 8]);
      SZ_HALF: rd_val = half_sel(ofs) ? WORD_W'(word[31:16]) : WORD_W'(word[15:0]);
      default: rd_val = word;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       hit;
    logic [7:0] src;
    always_comb begin
      case (size)
        SZ_BYTE: begin
          hit = (byte_lane(ofs) == 2'(g));
          src = wdata[7:0];
        end
        SZ_HALF: begin
          hit = (half_sel(ofs) == ((g / 2) != 0));
          src = wdata[(g % 2)*8 +: 8];
        end
        default: begin
          hit = 1'b1;
          src = wdata[g*8 +: 8];
        end
      endcase
    end
    assign merged[g*8 +: 8] = hit ? src : word[g*8 +: 8];
  end
endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
  import cfg_seq_pkg::*;
#(
  parameter int BUS_W        = 8,
  parameter int DEVFN_W      = 8,
  parameter int OFS_W        = 8,
  parameter int MAX_BUS      = 7,
  parameter int MAX_DEVFN    = 127,
  parameter int PORT_AW      = 16,
  parameter logic [PORT_AW-1:0] CSR_BASE = '0,
  parameter int ADDR_REG_OFS = 'h500,
  parameter int DATA_REG_OFS = 'h504
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [BUS_W-1:0]    req_bus,
  input  logic [DEVFN_W-1:0]  req_devfn,
  input  logic [OFS_W-1:0]    req_offset,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_rdata,
  output logic                rsp_notfound,
  output logic                prt_req,
  output logic                prt_we,
  output logic [PORT_AW-1:0]  prt_addr,
  output logic [WORD_W-1:0]   prt_wdata,
  input  logic                prt_done,
  input  logic [WORD_W-1:0]   prt_rdata,
  input  logic                prt_timeout
);
  localparam logic [PORT_AW-1:0] ADDR_REG = CSR_BASE + PORT_AW'(ADDR_REG_OFS);
  localparam logic [PORT_AW-1:0] DATA_REG = CSR_BASE + PORT_AW'(DATA_REG_OFS);

  seq_state_e        state_q, state_d;
  logic              wr_q, oor_q;
  acc_size_e         size_q;
  logic [1:0]        ofs_q;
  logic [WORD_W-1:0] wdata_q, aword_q, rd_word_q;

  logic              oor_now;
  logic [31:0]       aword_now;
  logic [WORD_W-1:0] lane_rd, lane_merged;

  // named events for the assertions
  logic req_fire, addr_done, data_rd_done, data_wr_done, is_word;
  assign req_fire     = req_valid && req_ready;
  assign addr_done    = (state_q == ST_AWAIT) && prt_done;
  assign data_rd_done = (state_q == ST_RWAIT) && prt_done;
  assign data_wr_done = (state_q == ST_WWAIT) && prt_done;
  assign is_word      = (size_q == SZ_WORD) || (size_q == SZ_WORD2);

  cfg_addr_form #(
    .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFS_W(OFS_W),
    .MAX_BUS(MAX_BUS), .MAX_DEVFN(MAX_DEVFN)
  ) u_addr (
    .bus(req_bus), .devfn(req_devfn), .ofs_hi(req_offset[OFS_W-1:2]),
    .out_of_range(oor_now), .addr_word(aword_now)
  );

  cfg_lane_unit u_lane (
    .word(rd_word_q), .size(size_q), .ofs(ofs_q), .wdata(wdata_q),
    .rd_val(lane_rd), .merged(lane_merged)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid) state_d = oor_now ? ST_RESP : ST_AWR;
      ST_AWR:    state_d = ST_AWAIT;
      ST_AWAIT:  if (prt_done) state_d = (wr_q && is_word) ? ST_DWR : ST_DRD;
      ST_DRD:    state_d = ST_RWAIT;
      ST_RWAIT:  if (prt_done) state_d = wr_q ? ST_DWR : ST_RESP;
      ST_DWR:    state_d = ST_WWAIT;
      ST_WWAIT:  if (prt_done) state_d = ST_RESP;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_q      <= 1'b0;
      oor_q     <= 1'b0;
      size_q    <= SZ_WORD;
      ofs_q     <= '0;
      wdata_q   <= '0;
      aword_q   <= '0;
      rd_word_q <= '0;
    end else begin
      state_q <= state_d;
      if (req_fire) begin
        wr_q    <= req_write;
        oor_q   <= oor_now;
        size_q  <= acc_size_e'(req_size);
        ofs_q   <= req_offset[1:0];
        wdata_q <= req_wdata;
        aword_q <= aword_now;
      end
      if (data_rd_done) rd_word_q <= prt_timeout ? '1 : prt_rdata;
    end
  end

  always_comb begin
    prt_req   = 1'b0;
    prt_we    = 1'b0;
    prt_addr  = DATA_REG;
    prt_wdata = '0;
    case (state_q)
      ST_AWR: begin
        prt_req = 1'b1; prt_we = 1'b1; prt_addr = ADDR_REG; prt_wdata = aword_q;
      end
      ST_DRD: prt_req = 1'b1;
      ST_DWR: begin
        prt_req = 1'b1; prt_we = 1'b1; prt_wdata = is_word ? wdata_q : lane_merged;
      end
      default: ;
    endcase
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_notfound = oor_q;
  assign rsp_rdata    = wr_q ? '0 : (oor_q ? size_ones(size_q) : lane_rd);

  // ---------------- assertions ----------------
  logic pend_q, word_wr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      word_wr_q <= 1'b0;
    end else begin
      if (prt_req) pend_q <= 1'b1;
      else if (prt_done) pend_q <= 1'b0;
      if (req_fire) word_wr_q <= req_write && req_size[1];
      else if (rsp_valid) word_wr_q <= 1'b0;
    end
  end

  a_r10_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prt_req |=> !prt_req) else $error("R10 prt_req longer than one cycle");

  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !prt_req) else $error("R10 second port cycle before completion");

  a_r3_reject_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && oor_now) |=> (rsp_valid && rsp_notfound && !prt_req))
    else $error("R3 rejected request touched the port");

  a_r2_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !oor_now) |=> (prt_req && prt_we && prt_addr == ADDR_REG))
    else $error("R2 operation did not start with address write");

  a_r1_type_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (prt_req && prt_addr == ADDR_REG) |-> (prt_wdata[0] == (prt_wdata[23:16] != 8'd0)))
    else $error("R1 Type 0/1 bit inconsistent with bus number");

  a_r9_timeout_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_done && prt_timeout) |=> (rd_word_q == '1))
    else $error("R9 timed-out read not forced to all ones");

  a_r8_word_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr_q |-> !(prt_req && !prt_we))
    else $error("R8 word write issued a data read");
endmodule

// File: tb/cfg_access_seq_bench.sv
module cfg_access_seq_bench;
  localparam logic [15:0] BASE  = 16'h4000;
  localparam logic [15:0] A_REG = BASE + 16'h0500;
  localparam logic [15:0] D_REG = BASE + 16'h0504;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [7:0]  req_bus = '0, req_devfn = '0, req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_notfound;
  logic [31:0] rsp_rdata;
  logic        prt_req, prt_we;
  logic [15:0] prt_addr;
  logic [31:0] prt_wdata;
  logic        prt_done = 1'b0, prt_timeout = 1'b0;
  logic [31:0] prt_rdata = '0;

  cfg_access_seq #(.CSR_BASE(BASE)) u_cfg_access_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_bus(req_bus), .req_devfn(req_devfn),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_notfound(rsp_notfound),
    .prt_req(prt_req), .prt_we(prt_we), .prt_addr(prt_addr), .prt_wdata(prt_wdata),
    .prt_done(prt_done), .prt_rdata(prt_rdata), .prt_timeout(prt_timeout)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- port model ----------------
  logic [31:0] mem     [0:4095];
  logic [31:0] exp_mem [0:4095];
  logic [31:0] cfg_aw = '0;
  int n_aw = 0, n_dr = 0, n_dw = 0, n_bad = 0;
  int cnt = 0;
  bit to_all = 0, to_rd = 0;
  logic        l_we;
  logic [15:0] l_addr;
  logic [31:0] l_wd;

  function automatic int bidx(input logic [31:0] aw);
    return int'({aw[17:16], aw[11:8], aw[7:2]});
  endfunction
  function automatic logic [31:0] init_val(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'hC3A5_0F0F;
  endfunction

  always @(posedge clk) begin
    prt_done    <= 1'b0;
    prt_timeout <= 1'b0;
    if (cnt != 0) begin
      if (prt_req) n_bad <= n_bad + 1;   // R10: strobe while busy
      cnt <= cnt - 1;
      if (cnt == 1) begin
        prt_done <= 1'b1;
        if (l_addr == A_REG && l_we) begin
          cfg_aw <= l_wd; n_aw <= n_aw + 1;
        end else if (l_addr == D_REG) begin
          if (l_we) n_dw <= n_dw + 1; else n_dr <= n_dr + 1;
          if (to_all || (to_rd && !l_we)) begin
            prt_timeout <= 1'b1; prt_rdata <= 32'hDEAD_BEEF;
          end else if (l_we) mem[bidx(cfg_aw)] <= l_wd;
          else prt_rdata <= mem[bidx(cfg_aw)];
        end else n_bad <= n_bad + 1;
      end
    end else if (prt_req) begin
      l_we <= prt_we; l_addr <= prt_addr; l_wd <= prt_wdata; cnt <= LAT;
    end
  end

  // ---------------- reference arithmetic ----------------
  function automatic logic [31:0] ref_aword(input logic [7:0] b, d, o);
    return (32'(b) << 16) | (32'(d) << 8) | 32'(o & 8'hFC) | ((b != 0) ? 32'd1 : 32'd0);
  endfunction
  function automatic logic [31:0] ref_read(input logic [31:0] w, input logic [1:0] sz, input logic [7:0] o);
    int sh;
    if (sz == 2'd0) begin
      sh = 8 * (3 - int'(o[1:0]));
      return (w >> sh) & 32'hFF;
    end
    if (sz == 2'd1) return o[1] ? (w & 32'hFFFF) : (w >> 16);
    return w;
  endfunction
  function automatic logic [31:0] ref_merge(input logic [31:0] w, input logic [1:0] sz, input logic [7:0] o, input logic [31:0] v);
    logic [31:0] m; int sh;
    if (sz == 2'd0) begin
      sh = 8 * (3 - int'(o[1:0])); m = 32'hFF << sh;
      return (w & ~m) | ((v & 32'hFF) << sh);
    end
    if (sz == 2'd1) begin
      sh = o[1] ? 0 : 16; m = 32'hFFFF << sh;
      return (w & ~m) | ((v & 32'hFFFF) << sh);
    end
    return v;
  endfunction
  function automatic logic [31:0] ones_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // ---------------- driver ----------------
  int d_aw, d_dr, d_dw;
  logic [31:0] got;
  bit nf;
  bit busy_seen;

  task automatic do_op(input bit wr, input logic [1:0] sz, input logic [7:0] b, d, o, input logic [31:0] wd);
    int a0, r0, w0;
    a0 = n_aw; r0 = n_dr; w0 = n_dw;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_bus = b; req_devfn = d; req_offset = o; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = !req_ready;
    while (!rsp_valid) @(negedge clk);
    got = rsp_rdata; nf = rsp_notfound;
    @(negedge clk);
    chk(!rsp_valid, "R11 rsp pulse", 32'(rsp_valid), 32'd0);
    d_aw = n_aw - a0; d_dr = n_dr - r0; d_dw = n_dw - w0;
  endtask

  task automatic read_back(input logic [7:0] b, d, o, input string tag);
    logic [31:0] e;
    e = exp_mem[bidx(ref_aword(b, d, o))];
    do_op(1'b0, 2'd2, b, d, o, 32'd0);
    chk(got == e, tag, got, e);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] buses [4];
    logic [7:0] devs  [3];
    logic [31:0] e, w, v;
    buses = '{8'd0, 8'd1, 8'd2, 8'd7};
    devs  = '{8'd0, 8'd5, 8'd127};
    for (int i = 0; i < 4096; i++) begin mem[i] = init_val(i); exp_mem[i] = init_val(i); end
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !prt_req, "R10 reset state",
        {29'd0, req_ready, rsp_valid, prt_req}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);

    // read sweep: R1 R2 R4 R5 R6 R11
    foreach (buses[bi]) foreach (devs[di]) for (int o = 0; o < 64; o++) for (int sz = 0; sz < 3; sz++) begin
      do_op(1'b0, 2'(sz), buses[bi], devs[di], 8'(o), 32'd0);
      w = exp_mem[bidx(ref_aword(buses[bi], devs[di], 8'(o)))];
      e = ref_read(w, 2'(sz), 8'(o));
      chk(got == e && !nf, (sz == 0) ? "R4 byte read" : (sz == 1) ? "R5 half read" : "R6 word read", got, e);
      chk(cfg_aw == ref_aword(buses[bi], devs[di], 8'(o)), "R1 address word", cfg_aw,
          ref_aword(buses[bi], devs[di], 8'(o)));
      chk(d_aw == 1 && d_dr == 1 && d_dw == 0, "R2 read cycle sequence", 32'({d_aw[7:0], d_dr[7:0], d_dw[7:0]}), 32'h010100);
      chk(busy_seen, "R10 ready low while busy", 32'(busy_seen), 32'd1);
    end

    // write sweep: R7 R8
    for (int bsel = 0; bsel < 2; bsel++) for (int o = 0; o < 16; o++) for (int sz = 0; sz < 3; sz++) begin
      logic [7:0] b;
      b = (bsel == 0) ? 8'd0 : 8'd7;
      v = 32'hA5C3_1E00 ^ 32'(o * 37 + sz * 101);
      do_op(1'b1, 2'(sz), b, 8'd127, 8'(o), v);
      exp_mem[bidx(ref_aword(b, 8'd127, 8'(o)))] = ref_merge(exp_mem[bidx(ref_aword(b, 8'd127, 8'(o)))], 2'(sz), 8'(o), v);
      chk(!nf && got == 32'd0, "R11 write response", got, 32'd0);
      if (sz == 2) chk(d_dr == 0 && d_dw == 1, "R8 word write direct", 32'({d_dr[7:0], d_dw[7:0]}), 32'h0001);
      else         chk(d_dr == 1 && d_dw == 1, "R7 rmw sequence", 32'({d_dr[7:0], d_dw[7:0]}), 32'h0101);
      read_back(b, 8'd127, 8'(o), (sz == 2) ? "R8 word write data" : "R7 preserved bytes");
    end

    // rejects: R3
    for (int k = 0; k < 3; k++) for (int sz = 0; sz < 3; sz++) begin
      logic [7:0] b, d;
      b = (k == 0) ? 8'd8 : (k == 1) ? 8'd0 : 8'd255;
      d = (k == 1) ? 8'd128 : (k == 2) ? 8'd255 : 8'd3;
      do_op(1'b0, 2'(sz), b, d, 8'h10, 32'd0);
      chk(nf && got == ones_of(2'(sz)), "R3 reject read data", got, ones_of(2'(sz)));
      chk(d_aw + d_dr + d_dw == 0, "R3 no port cycle", 32'(d_aw + d_dr + d_dw), 32'd0);
      do_op(1'b1, 2'(sz), b, d, 8'h10, 32'h1234_5678);
      chk(nf && d_aw + d_dr + d_dw == 0, "R3 reject write", 32'(d_aw + d_dr + d_dw), 32'd0);
    end
    read_back(8'd0, 8'd0, 8'h10, "R3 memory untouched");
    read_back(8'd0, 8'd8, 8'h10, "R3 memory untouched");

    // timeouts: R9
    to_all = 1;
    for (int sz = 0; sz < 3; sz++) begin
      do_op(1'b0, 2'(sz), 8'd2, 8'd5, 8'h05, 32'd0);
      chk(!nf && got == ones_of(2'(sz)), "R9 timed-out read", got, ones_of(2'(sz)));
    end
    to_all = 0; to_rd = 1;
    for (int sz = 0; sz < 2; sz++) begin
      do_op(1'b1, 2'(sz), 8'd1, 8'd0, 8'(8 + sz * 2), 32'h0000_3C5A);
      exp_mem[bidx(ref_aword(8'd1, 8'd0, 8'(8 + sz * 2)))] = ref_merge(32'hFFFF_FFFF, 2'(sz), 8'(8 + sz * 2), 32'h0000_3C5A);
    end
    to_rd = 0;
    read_back(8'd1, 8'd0, 8'd8,  "R9 rmw merged into ones");
    read_back(8'd1, 8'd0, 8'd10, "R9 rmw merged into ones");

    chk(n_bad == 0, "R10 port protocol", 32'(n_bad), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule